// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches one gated power domain on and off in hardware. A one-cycle request on `reqOn` or `reqOff` starts an ordered sequence. The sequence drives a two-stage power switch, isolation, the domain's active-low reset, a clock-disable line, the SRAM power-down lines and the bus-protection request lines. Between steps it waits on acknowledges returned by the domain. The domain counts as powered only when both switch acknowledges are high. It counts as unpowered only when both are low. While exactly one of the two is high, the domain is in a transitional state.

Each wait is bounded by a cycle counter. If the acknowledges never arrive, the sequence stops where it is and raises a sticky error. The masks for the SRAM acknowledge and the bus-protection lines are parameters. A zero mask removes the matching handshake from both sequences, so one block serves domains with and without SRAM banks or protected bus ports.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the domain is held off: both switch enables low, isolation high, `rstDomN` low, clock disable high, every `sramPdn` bit high, `busProtReq` equal to the protection mask, and `busy`, `done`, `isOn` and `errTimeout` all low.
- R2: Power-up changes the outputs in this order: primary enable rises, secondary enable rises, clock disable falls, isolation falls, `rstDomN` rises, `sramPdn` clears, `busProtReq` clears.
- R3: Power-down changes the outputs in this order: `busProtReq` rises to the mask, `sramPdn` sets, isolation rises, `rstDomN` falls, clock disable rises, primary enable falls, secondary enable falls.
- R4: Power-up does not move past the switch step until both acknowledges are high. Power-down does not finish until both are low. `transit` is high exactly when one acknowledge is high, and that state ends neither wait.
- R5: With a nonzero SRAM mask, power-up waits until every masked `sramAck` bit is low before it touches bus protection. Power-down waits until every masked bit is high before it raises isolation.
- R6: With a zero SRAM mask, neither SRAM wait takes place. On power-down, isolation rises in the cycle right after `sramPdn` sets. On power-up, `done` appears together with the clearing of `sramPdn`.
- R7: With a nonzero protection mask, power-down waits until every masked `busProtAck` bit is high before setting `sramPdn`. Power-up waits until they are all low before it finishes. With a zero mask, `busProtReq` never changes, and power-down sets `sramPdn` one cycle after `busy` rises.
- R8: A wait that is not satisfied within `TIMEOUT_CYC` cycles ends the sequence. `errTimeout` rises exactly `TIMEOUT_CYC` cycles after the step that opened the wait. `busy` drops, there is no `done`, `isOn` keeps its value, and the outputs stay where they stopped.
- R9: At most one domain control output (`pwrEnPri`, `pwrEnSec`, `isoEn`, `rstDomN`, `clkDis`, `sramPdn`, `busProtReq`) changes in any cycle.
- R10: A request that arrives while `busy` is high is dropped and does not alter the running sequence.
- R11: A request for the state the domain is already in gives `done` in the next cycle, with no control output change and `busy` staying low.
- R12: A successful sequence ends with a one-cycle `done`, with `busy` low and `isOn` showing the new state. An accepted request clears `errTimeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqOn | input | 1 | Request power-up (has priority if both requests are high) |
| reqOff | input | 1 | Request power-down |
| pwrAckPri | input | 1 | Primary switch acknowledge |
| pwrAckSec | input | 1 | Secondary switch acknowledge |
| sramAck | input | SRAM_ACK_W | SRAM power-down acknowledges |
| busProtAck | input | PROT_W | Bus-protection acknowledges |
| pwrEnPri | output | 1 | Primary switch enable |
| pwrEnSec | output | 1 | Secondary switch enable |
| isoEn | output | 1 | Isolation enable |
| rstDomN | output | 1 | Domain reset, active low |
| clkDis | output | 1 | Domain clock disable |
| sramPdn | output | SRAM_REQ_W | SRAM power-down requests |
| busProtReq | output | PROT_W | Bus-protection requests |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| isOn | output | 1 | Domain is powered |
| transit | output | 1 | Exactly one switch acknowledge is high |
| errTimeout | output | 1 | Sticky timeout error |

## Verification
The bench holds the secondary acknowledge low and checks that the sequence neither advances nor completes while `transit` is high. It then checks that the error appears exactly `TIMEOUT_CYC` cycles after the secondary enable rose. A counter that is not reloaded per wait, or that is off by one, moves that edge. A design that reads a single acknowledge would continue into the clock and isolation steps too early. A second instance with zero masks measures the cycle gaps around `sramPdn`. A design that still passes through the skipped waits adds a cycle there, and one that toggles protection shows activity on `busProtReq`. Requests issued mid-sequence and requests for the current state are also driven: a design that restarts or re-runs the sequence changes the control outputs or delays `done`.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

  // strobes from sequencer control to datapath
  typedef struct packed {
    logic setEnPri;
    logic clrEnPri;
    logic setEnSec;
    logic clrEnSec;
    logic setIso;
    logic clrIso;
    logic relRst;
    logic asrRst;
    logic setClkDis;
    logic clrClkDis;
    logic setSram;
    logic clrSram;
    logic setProt;
    logic clrProt;
    logic loadTmr;
    logic markOn;
    logic markOff;
    logic markDone;
    logic raiseErr;
    logic clearErr;
  } seqStrobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic pwrAllOn;
    logic pwrAllOff;
    logic sramAllSet;
    logic sramAllClr;
    logic protAllSet;
    logic protAllClr;
    logic tmrZero;
  } seqStatus_t;

  typedef enum logic [4:0] {
    S_IDLE,
    S_UP_EN1,
    S_UP_EN2,
    S_UP_WPWR,
    S_UP_CLK,
    S_UP_ISO,
    S_UP_RST,
    S_UP_SRAM,
    S_UP_WSRAM,
    S_UP_PROT,
    S_UP_WPROT,
    S_DN_PROT,
    S_DN_WPROT,
    S_DN_SRAM,
    S_DN_WSRAM,
    S_DN_ISO,
    S_DN_RST,
    S_DN_CLK,
    S_DN_EN1,
    S_DN_EN2,
    S_DN_WPWR
  } seqState_t;

endpackage

// File: rtl/pwr_gate_dpath.sv
module pwr_gate_dpath
  import pwr_gate_pkg::*;
#(
  parameter int SRAM_REQ_W = 4,
  parameter int SRAM_ACK_W = 4,
  parameter logic [SRAM_ACK_W-1:0] SRAM_ACK_MASK = '1,
  parameter int PROT_W = 2,
  parameter logic [PROT_W-1:0] PROT_MASK = '1,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            stb,
  input  logic                  pwrAckPri,
  input  logic                  pwrAckSec,
  input  logic [SRAM_ACK_W-1:0] sramAck,
  input  logic [PROT_W-1:0]     busProtAck,
  output seqStatus_t            status,
  output logic                  pwrEnPri,
  output logic                  pwrEnSec,
  output logic                  isoEn,
  output logic                  rstDomN,
  output logic                  clkDis,
  output logic [SRAM_REQ_W-1:0] sramPdn,
  output logic [PROT_W-1:0]     busProtReq,
  output logic                  done,
  output logic                  isOn,
  output logic                  transit,
  output logic                  errTimeout
);

  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(TIMEOUT_CYC - 1);

  logic [TMR_W-1:0] tmrCnt;
  logic [SRAM_ACK_W-1:0] sramMasked;
  logic [PROT_W-1:0] protMasked;

  assign sramMasked = sramAck & SRAM_ACK_MASK;
  assign protMasked = busProtAck & PROT_MASK;

  always_comb begin
    status.pwrAllOn   = pwrAckPri & pwrAckSec;
    status.pwrAllOff  = ~pwrAckPri & ~pwrAckSec;
    status.sramAllSet = (sramMasked == SRAM_ACK_MASK);
    status.sramAllClr = (sramMasked == '0);
    status.protAllSet = (protMasked == PROT_MASK);
    status.protAllClr = (protMasked == '0);
    status.tmrZero    = (tmrCnt == '0);
  end

  assign transit = pwrAckPri ^ pwrAckSec;

  // domain control word; reset value keeps the domain off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrEnPri   <= 1'b0;
      pwrEnSec   <= 1'b0;
      isoEn      <= 1'b1;
      rstDomN    <= 1'b0;
      clkDis     <= 1'b1;
      sramPdn    <= '1;
      busProtReq <= PROT_MASK;
    end else begin
      if (stb.setEnPri)  pwrEnPri <= 1'b1;
      if (stb.clrEnPri)  pwrEnPri <= 1'b0;
      if (stb.setEnSec)  pwrEnSec <= 1'b1;
      if (stb.clrEnSec)  pwrEnSec <= 1'b0;
      if (stb.setIso)    isoEn <= 1'b1;
      if (stb.clrIso)    isoEn <= 1'b0;
      if (stb.relRst)    rstDomN <= 1'b1;
      if (stb.asrRst)    rstDomN <= 1'b0;
      if (stb.setClkDis) clkDis <= 1'b1;
      if (stb.clrClkDis) clkDis <= 1'b0;
      if (stb.setSram)   sramPdn <= '1;
      if (stb.clrSram)   sramPdn <= '0;
      if (stb.setProt)   busProtReq <= PROT_MASK;
      if (stb.clrProt)   busProtReq <= '0;
    end
  end

  // wait timer: reloaded when a wait opens, counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (stb.loadTmr) begin
      tmrCnt <= TMR_LOAD;
    end else if (tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done       <= 1'b0;
      isOn       <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      done <= stb.markDone;
      if (stb.markOn)   isOn <= 1'b1;
      if (stb.markOff)  isOn <= 1'b0;
      if (stb.clearErr) errTimeout <= 1'b0;
      if (stb.raiseErr) errTimeout <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter bit HAS_SRAM_WAIT = 1'b1,
  parameter bit HAS_PROT      = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqOn,
  input  logic       reqOff,
  input  logic       isOn,
  input  seqStatus_t status,
  output seqStrobe_t stb,
  output logic       busy
);

  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      S_IDLE: begin
        if (reqOn) begin
          if (isOn) begin
            stb.markDone = 1'b1;
          end else begin
            stb.clearErr = 1'b1;
            nxt = S_UP_EN1;
          end
        end else if (reqOff) begin
          if (!isOn) begin
            stb.markDone = 1'b1;
          end else begin
            stb.clearErr = 1'b1;
            nxt = HAS_PROT ? S_DN_PROT : S_DN_SRAM;
          end
        end
      end
      // power-up
      S_UP_EN1: begin
        stb.setEnPri = 1'b1;
        nxt = S_UP_EN2;
      end
      S_UP_EN2: begin
        stb.setEnSec = 1'b1;
        stb.loadTmr  = 1'b1;
        nxt = S_UP_WPWR;
      end
      S_UP_WPWR: begin
        if (status.pwrAllOn) begin
          nxt = S_UP_CLK;
        end else if (status.tmrZero) begin
          stb.raiseErr = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_UP_CLK: begin
        stb.clrClkDis = 1'b1;
        nxt = S_UP_ISO;
      end
      S_UP_ISO: begin
        stb.clrIso = 1'b1;
        nxt = S_UP_RST;
      end
      S_UP_RST: begin
        stb.relRst = 1'b1;
        nxt = S_UP_SRAM;
      end
      S_UP_SRAM: begin
        stb.clrSram = 1'b1;
        stb.loadTmr = 1'b1;
        if (HAS_SRAM_WAIT) begin
          nxt = S_UP_WSRAM;
        end else if (HAS_PROT) begin
          nxt = S_UP_PROT;
        end else begin
          stb.markOn   = 1'b1;
          stb.markDone = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_UP_WSRAM: begin
        if (status.sramAllClr) begin
          if (HAS_PROT) begin
            nxt = S_UP_PROT;
          end else begin
            stb.markOn   = 1'b1;
            stb.markDone = 1'b1;
            nxt = S_IDLE;
          end
        end else if (status.tmrZero) begin
          stb.raiseErr = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_UP_PROT: begin
        stb.clrProt = 1'b1;
        stb.loadTmr = 1'b1;
        nxt = S_UP_WPROT;
      end
      S_UP_WPROT: begin
        if (status.protAllClr) begin
          stb.markOn   = 1'b1;
          stb.markDone = 1'b1;
          nxt = S_IDLE;
        end else if (status.tmrZero) begin
          stb.raiseErr = 1'b1;
          nxt = S_IDLE;
        end
      end
      // power-down
      S_DN_PROT: begin
        stb.setProt = 1'b1;
        stb.loadTmr = 1'b1;
        nxt = S_DN_WPROT;
      end
      S_DN_WPROT: begin
        if (status.protAllSet) begin
          nxt = S_DN_SRAM;
        end else if (status.tmrZero) begin
          stb.raiseErr = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_DN_SRAM: begin
        stb.setSram = 1'b1;
        stb.loadTmr = 1'b1;
        nxt = HAS_SRAM_WAIT ? S_DN_WSRAM : S_DN_ISO;
      end
      S_DN_WSRAM: begin
        if (status.sramAllSet) begin
          nxt = S_DN_ISO;
        end else if (status.tmrZero) begin
          stb.raiseErr = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_DN_ISO: begin
        stb.setIso = 1'b1;
        nxt = S_DN_RST;
      end
      S_DN_RST: begin
        stb.asrRst = 1'b1;
        nxt = S_DN_CLK;
      end
      S_DN_CLK: begin
        stb.setClkDis = 1'b1;
        nxt = S_DN_EN1;
      end
      S_DN_EN1: begin
        stb.clrEnPri = 1'b1;
        nxt = S_DN_EN2;
      end
      S_DN_EN2: begin
        stb.clrEnSec = 1'b1;
        stb.loadTmr  = 1'b1;
        nxt = S_DN_WPWR;
      end
      S_DN_WPWR: begin
        if (status.pwrAllOff) begin
          stb.markOff  = 1'b1;
          stb.markDone = 1'b1;
          nxt = S_IDLE;
        end else if (status.tmrZero) begin
          stb.raiseErr = 1'b1;
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pwr_gate_pkg::*;
#(
  parameter int SRAM_REQ_W = 4,
  parameter int SRAM_ACK_W = 4,
  parameter logic [SRAM_ACK_W-1:0] SRAM_ACK_MASK = '1,
  parameter int PROT_W = 2,
  parameter logic [PROT_W-1:0] PROT_MASK = '1,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqOn,
  input  logic                  reqOff,
  input  logic                  pwrAckPri,
  input  logic                  pwrAckSec,
  input  logic [SRAM_ACK_W-1:0] sramAck,
  input  logic [PROT_W-1:0]     busProtAck,
  output logic                  pwrEnPri,
  output logic                  pwrEnSec,
  output logic                  isoEn,
  output logic                  rstDomN,
  output logic                  clkDis,
  output logic [SRAM_REQ_W-1:0] sramPdn,
  output logic [PROT_W-1:0]     busProtReq,
  output logic                  busy,
  output logic                  done,
  output logic                  isOn,
  output logic                  transit,
  output logic                  errTimeout
);

  localparam bit HAS_SRAM_WAIT = (SRAM_ACK_MASK != '0);
  localparam bit HAS_PROT      = (PROT_MASK != '0);

  seqStrobe_t stb;
  seqStatus_t status;

  pwr_gate_ctrl #(
    .HAS_SRAM_WAIT(HAS_SRAM_WAIT),
    .HAS_PROT(HAS_PROT)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .reqOn(reqOn),
    .reqOff(reqOff),
    .isOn(isOn),
    .status(status),
    .stb(stb),
    .busy(busy)
  );

  pwr_gate_dpath #(
    .SRAM_REQ_W(SRAM_REQ_W),
    .SRAM_ACK_W(SRAM_ACK_W),
    .SRAM_ACK_MASK(SRAM_ACK_MASK),
    .PROT_W(PROT_W),
    .PROT_MASK(PROT_MASK),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) dpath_i (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .pwrAckPri(pwrAckPri),
    .pwrAckSec(pwrAckSec),
    .sramAck(sramAck),
    .busProtAck(busProtAck),
    .status(status),
    .pwrEnPri(pwrEnPri),
    .pwrEnSec(pwrEnSec),
    .isoEn(isoEn),
    .rstDomN(rstDomN),
    .clkDis(clkDis),
    .sramPdn(sramPdn),
    .busProtReq(busProtReq),
    .done(done),
    .isOn(isOn),
    .transit(transit),
    .errTimeout(errTimeout)
  );

endmodule

// File: rtl/pwr_gate_chk.sv
module pwr_gate_chk #(
  parameter int SRAM_REQ_W = 4,
  parameter int PROT_W = 2,
  parameter logic [PROT_W-1:0] PROT_MASK = '1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  pwrAckPri,
  input logic                  pwrAckSec,
  input logic                  pwrEnPri,
  input logic                  pwrEnSec,
  input logic                  isoEn,
  input logic                  rstDomN,
  input logic                  clkDis,
  input logic [SRAM_REQ_W-1:0] sramPdn,
  input logic [PROT_W-1:0]     busProtReq,
  input logic                  busy,
  input logic                  done,
  input logic                  isOn,
  input logic                  errTimeout
);

  // R4
  off_needs_acks_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isOn) |-> $past(!pwrAckPri && !pwrAckSec));

  // R2
  iso_drop_after_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isoEn) |-> (!clkDis && pwrEnPri && pwrEnSec));

  // R3
  iso_rise_after_sram_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isoEn) |-> (sramPdn == '1 && busProtReq == PROT_MASK));

  // R9
  one_change_per_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({pwrEnPri != $past(pwrEnPri), pwrEnSec != $past(pwrEnSec),
                isoEn != $past(isoEn), rstDomN != $past(rstDomN),
                clkDis != $past(clkDis), sramPdn != $past(sramPdn),
                busProtReq != $past(busProtReq)}) <= 1);

  // R12
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  error_aborts_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> (!busy && !done));

endmodule

bind pwr_gate_seq pwr_gate_chk #(
  .SRAM_REQ_W(SRAM_REQ_W),
  .PROT_W(PROT_W),
  .PROT_MASK(PROT_MASK)
) chk_i (.*);

// File: tb/pwr_gate_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_gate_seq_tb_top;

  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  // main instance: full masks
  logic reqOn = 1'b0, reqOff = 1'b0;
  logic ackPri = 1'b0, ackSec = 1'b0;
  logic [3:0] sramAck = 4'hF;
  logic [1:0] protAck = 2'b11;
  logic enPri, enSec, iso, rstD, clkD, busy, done, isOn, transit, err;
  logic [3:0] sramPdn;
  logic [1:0] protReq;

  pwr_gate_seq #(
    .SRAM_REQ_W(4), .SRAM_ACK_W(4), .SRAM_ACK_MASK(4'hF),
    .PROT_W(2), .PROT_MASK(2'b11), .TIMEOUT_CYC(TMO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqOn(reqOn), .reqOff(reqOff),
    .pwrAckPri(ackPri), .pwrAckSec(ackSec), .sramAck(sramAck), .busProtAck(protAck),
    .pwrEnPri(enPri), .pwrEnSec(enSec), .isoEn(iso), .rstDomN(rstD), .clkDis(clkD),
    .sramPdn(sramPdn), .busProtReq(protReq), .busy(busy), .done(done), .isOn(isOn),
    .transit(transit), .errTimeout(err)
  );

  // second instance: zero masks
  logic reqOn2 = 1'b0, reqOff2 = 1'b0;
  logic ackPri2 = 1'b0, ackSec2 = 1'b0;
  logic enPri2, enSec2, iso2, rstD2, clkD2, busy2, done2, isOn2, transit2, err2;
  logic [3:0] sramPdn2;
  logic [1:0] protReq2;

  pwr_gate_seq #(
    .SRAM_REQ_W(4), .SRAM_ACK_W(4), .SRAM_ACK_MASK(4'h0),
    .PROT_W(2), .PROT_MASK(2'b00), .TIMEOUT_CYC(TMO)
  ) dut2_i (
    .clk(clk), .rstN(rstN), .reqOn(reqOn2), .reqOff(reqOff2),
    .pwrAckPri(ackPri2), .pwrAckSec(ackSec2), .sramAck(4'h0), .busProtAck(2'b00),
    .pwrEnPri(enPri2), .pwrEnSec(enSec2), .isoEn(iso2), .rstDomN(rstD2), .clkDis(clkD2),
    .sramPdn(sramPdn2), .busProtReq(protReq2), .busy(busy2), .done(done2), .isOn(isOn2),
    .transit(transit2), .errTimeout(err2)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- monitor and domain model (negedge) ----------------
  int cyc = 0;
  int seqLog [0:15];
  int seqLen = 0;
  int multiCnt = 0;
  int violR4 = 0, violR5 = 0, violR7 = 0;
  bit sawTransit = 1'b0;
  int doneRises = 0;
  int cycEnSecRise = 0, cycErrRise = 0;
  int cycSram2Rise = 0, cycSram2Fall = 0, cycIso2Rise = 0, cycBusy2Rise = 0, cycDone2Rise = 0;
  int prot2Changes = 0;
  bit holdSecLow = 1'b0;

  logic pEnPri, pEnSec, pIso, pRstD, pClkD, pDone, pErr, pIsOn;
  logic [3:0] pSram;
  logic [1:0] pProt;
  logic pSram2Any, pIso2, pBusy2, pDone2;
  logic [1:0] pProt2;
  logic [2:0] dlyPri, dlyPri2;
  logic [3:0] dlySec, dlySec2;
  logic [3:0] dlySram0, dlySram1;
  logic [1:0] dlyProt0, dlyProt1;

  task automatic logEv(input int id, inout int n);
    if (seqLen < 16) seqLog[seqLen] = id;
    seqLen++;
    n++;
  endtask

  always @(negedge clk) begin
    int n;
    cyc++;
    n = 0;
    if (rstN) begin
      if (enPri !== pEnPri) logEv(1, n);
      if (enSec !== pEnSec) begin
        logEv(2, n);
        if (enSec) cycEnSecRise = cyc;
      end
      if (iso !== pIso) logEv(3, n);
      if (rstD !== pRstD) logEv(4, n);
      if (clkD !== pClkD) begin
        logEv(5, n);
        if (!clkD && !(ackPri && ackSec)) violR4++;
      end
      if (sramPdn !== pSram) begin
        logEv(6, n);
        if (sramPdn == 4'hF && protAck != 2'b11) violR7++;
      end
      if (protReq !== pProt) begin
        logEv(7, n);
        if (protReq == 2'b00 && sramAck != 4'h0) violR5++;
      end
      if (n > 1) multiCnt++;
      if (iso && !pIso && sramAck != 4'hF) violR5++;
      if (!isOn && pIsOn && (ackPri || ackSec)) violR4++;
      if (isOn && !pIsOn && protAck != 2'b00) violR7++;
      if (transit) sawTransit = 1'b1;
      if (done && !pDone) doneRises++;
      if (err && !pErr) cycErrRise = cyc;
      // second instance
      if ((|sramPdn2) && !pSram2Any) cycSram2Rise = cyc;
      if (!(|sramPdn2) && pSram2Any) cycSram2Fall = cyc;
      if (iso2 && !pIso2) cycIso2Rise = cyc;
      if (busy2 && !pBusy2) cycBusy2Rise = cyc;
      if (done2 && !pDone2) cycDone2Rise = cyc;
      if (protReq2 !== pProt2) prot2Changes++;
    end
    pEnPri = enPri; pEnSec = enSec; pIso = iso; pRstD = rstD; pClkD = clkD;
    pSram = sramPdn; pProt = protReq; pDone = done; pErr = err; pIsOn = isOn;
    pSram2Any = |sramPdn2; pIso2 = iso2; pBusy2 = busy2; pDone2 = done2; pProt2 = protReq2;
    // domain model: acknowledges follow requests after fixed delays
    dlyPri  = {dlyPri[1:0], enPri};
    dlySec  = {dlySec[2:0], enSec};
    dlyPri2 = {dlyPri2[1:0], enPri2};
    dlySec2 = {dlySec2[2:0], enSec2};
    dlySram1 = dlySram0; dlySram0 = sramPdn;
    dlyProt1 = dlyProt0; dlyProt0 = protReq;
    ackPri  = dlyPri[2];
    ackSec  = holdSecLow ? 1'b0 : dlySec[3];
    ackPri2 = dlyPri2[2];
    ackSec2 = dlySec2[3];
    sramAck = dlySram1;
    protAck = dlyProt1;
  end

  initial begin
    dlyPri = '0; dlySec = '0; dlyPri2 = '0; dlySec2 = '0;
    dlySram0 = 4'hF; dlySram1 = 4'hF; dlyProt0 = 2'b11; dlyProt1 = 2'b11;
  end

  // ---------------- helpers ----------------
  task automatic pulse(input bit on, input bit second);
    @(negedge clk);
    if (second) begin reqOn2 = on; reqOff2 = !on; end
    else begin reqOn = on; reqOff = !on; end
    @(negedge clk);
    reqOn = 1'b0; reqOff = 1'b0; reqOn2 = 1'b0; reqOff2 = 1'b0;
  endtask

  task automatic waitIdle(input bit second);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (second ? !busy2 : !busy) break;
    end
  endtask

  task automatic checkSeq(input string req, input int e0, e1, e2, e3, e4, e5, e6);
    int exp [0:6];
    exp = '{e0, e1, e2, e3, e4, e5, e6};
    chk(req, seqLen, 7);
    for (int i = 0; i < 7; i++) chk(req, seqLog[i], exp[i]);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 enPri", enPri, 0);
    chk("R1 enSec", enSec, 0);
    chk("R1 iso", iso, 1);
    chk("R1 rstDomN", rstD, 0);
    chk("R1 clkDis", clkD, 1);
    chk("R1 sramPdn", sramPdn, 4'hF);
    chk("R1 busProtReq", protReq, 2'b11);
    chk("R1 busy/done/isOn/err", {busy, done, isOn, err}, 4'b0000);
  endtask

  task automatic t_power_up();
    int d0;
    seqLen = 0; d0 = doneRises;
    pulse(1'b1, 1'b0);
    waitIdle(1'b0);
    chk("R12 done on busy fall", done, 1);
    chk("R12 isOn", isOn, 1);
    @(negedge clk);
    chk("R12 done one cycle", done, 0);
    chk("R12 one done", doneRises - d0, 1);
    checkSeq("R2 order", 1, 2, 5, 3, 4, 6, 7);
    chk("R4 R5 R7 waits on power-up", violR4 + violR5 + violR7, 0);
  endtask

  task automatic t_power_down();
    seqLen = 0;
    pulse(1'b0, 1'b0);
    waitIdle(1'b0);
    chk("R12 isOn cleared", isOn, 0);
    chk("R12 done", done, 1);
    @(negedge clk);
    checkSeq("R3 order", 7, 6, 3, 4, 5, 1, 2);
    chk("R4 R5 R7 waits on power-down", violR4 + violR5 + violR7, 0);
    chk("R9 single change per cycle", multiCnt, 0);
  endtask

  task automatic t_same_state();
    seqLen = 0;
    pulse(1'b0, 1'b0);
    chk("R11 done next cycle", done, 1);
    chk("R11 not busy", busy, 0);
    repeat (3) @(negedge clk);
    chk("R11 no output change", seqLen, 0);
    chk("R11 still off", isOn, 0);
  endtask

  task automatic t_busy_ignore();
    seqLen = 0;
    pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    pulse(1'b0, 1'b0);
    waitIdle(1'b0);
    chk("R10 reqOff ignored, domain on", isOn, 1);
    @(negedge clk);
    checkSeq("R10 sequence unchanged", 1, 2, 5, 3, 4, 6, 7);
    repeat (4) @(negedge clk);
    chk("R10 stays idle", busy, 0);
    t_power_down();
  endtask

  task automatic t_timeout();
    int d0;
    holdSecLow = 1'b1;
    sawTransit = 1'b0;
    d0 = doneRises;
    pulse(1'b1, 1'b0);
    waitIdle(1'b0);
    @(negedge clk);
    chk("R8 error raised", err, 1);
    chk("R8 error after TIMEOUT_CYC", cycErrRise - cycEnSecRise, TMO);
    chk("R8 no done", doneRises - d0, 0);
    chk("R8 isOn kept", isOn, 0);
    chk("R8 outputs held, clock still off", clkD, 1);
    chk("R4 transitional seen", sawTransit, 1);
    chk("R4 wait not ended by one ack", iso, 1);
    holdSecLow = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 transit low with both acks", transit, 0);
    pulse(1'b1, 1'b0);
    chk("R12 error cleared on accept", err, 0);
    waitIdle(1'b0);
    chk("R12 retry completes", isOn, 1);
    @(negedge clk);
    t_power_down();
  endtask

  task automatic t_zero_masks();
    pulse(1'b1, 1'b1);
    waitIdle(1'b1);
    @(negedge clk);
    chk("R6 up done with sram clear", cycDone2Rise, cycSram2Fall);
    chk("R6 up ok", {isOn2, err2}, 2'b10);
    pulse(1'b0, 1'b1);
    waitIdle(1'b1);
    @(negedge clk);
    chk("R6 iso right after sram set", cycIso2Rise - cycSram2Rise, 1);
    chk("R7 sram set one cycle after busy", cycSram2Rise - cycBusy2Rise, 1);
    chk("R7 protection untouched", prot2Changes, 0);
    chk("R6 down ok", {isOn2, err2}, 2'b00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_power_up();
    t_power_down();
    t_same_state();
    t_busy_ignore();
    t_timeout();
    t_zero_masks();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule